// File: doc/BRIEF.md
# Multi-Lane Triggered Daisy-Chain Shifter

This block sends serial bit streams into several separate chains of shift-register peripherals, such as DAC chains and analog-switch chains. All chains share one serial clock and one update strobe. A host fills a buffer for each lane ahead of time, over a valid/ready write port, one 16-bit word per beat. Each lane also has its own programmed frame length in bits. When an external trigger input rises, every lane shifts out its frame in lockstep on the shared clock. The clock then rests low for one phase, and the update strobe pulses so that every device in every chain loads its new state at the same moment.

A switch-array device takes one 16-bit word, one bit per switch, so the frame of a switch chain is 16 times the number of devices in it. Word 0 of a lane holds the word for the device farthest down the chain. It is shifted first, most significant bit first. Lanes with shorter frames go quiet once their frame ends, while the clock keeps running until the longest lane is finished.

Back-pressure: `wr_ready` is low for the whole of a transfer. A write beat moves only on a clock edge where `wr_valid` and `wr_ready` are both high. The host must hold a beat until it is accepted. A beat offered while `wr_ready` is low is not taken.

Top module: `chain_shifter`

## Requirements
- R1: While reset is held and after reset, `sclk`, `sdo`, `upd`, `busy`, `done` and `overrun` are 0 and `wr_ready` is 1. Every buffer word starts at 0.
- R2: A write beat is accepted when `wr_valid` and `wr_ready` are both high. It stores `wr_data` as word `wr_addr` of lane `wr_lane`. `wr_ready` is low while `busy` is high, and a beat offered then changes nothing. A beat with `wr_lane` of 5 or more changes nothing.
- R3: The trigger passes through a two-flop synchronizer and launches on a rising edge only. `busy` rises on the third rising clock edge at which `trig_in` is sampled high, counting the first. A trigger held high launches only one transfer.
- R4: Each half of the serial clock lasts P system cycles, where P = max(`cfg_div`, 2) + 1. `sclk` starts low after launch, so each of the N bits takes 2P cycles, where N is the longest lane frame.
- R5: Bit k of a lane, counting from k = 0 as the first bit shifted, is bit 15 − (k mod 16) of word k/16. `sdo` changes only when `sclk` falls, and at launch.
- R6: A lane whose frame length is below N drives 0 from its bit index equal to its length onward. A programmed length above 64 is treated as 64.
- R7: After the last falling edge of `sclk`, `sclk` and `sdo` stay low for P cycles. `upd` is then high for P cycles and is never high together with `sclk`.
- R8: `done` is high for exactly the one cycle after `upd` falls, and `busy` goes low in that same cycle.
- R9: A trigger edge that arrives while `busy` is high is ignored and sets `overrun`. `overrun` stays set until the next launched transfer clears it.
- R10: `cfg_len` and `cfg_div` are captured at launch. Changing them during a transfer has no effect on it.
- R11: A transfer in which every lane length is 0 skips shifting: the P-cycle gap and the P-cycle `upd` pulse follow launch directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Write beat can be accepted (idle) |
| wr_lane | input | 3 | Lane selected by the write |
| wr_addr | input | 2 | Word index inside the lane buffer |
| wr_data | input | 16 | Word to store |
| cfg_len | input | 35 | Frame length in bits per lane, 7 bits each, lane 0 lowest |
| cfg_div | input | 8 | Serial clock divider setting |
| trig_in | input | 1 | Asynchronous external trigger |
| sclk | output | 1 | Shared serial clock |
| sdo | output | 5 | Serial data, one bit per lane |
| upd | output | 1 | Shared update/latch strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| overrun | output | 1 | Sticky flag: a trigger was ignored |

## Verification
Launch is due two edges after the trigger is first sampled high. `sclk` toggles every P cycles after that. The gap and the `upd` pulse last P cycles each, and `done` is due in the cycle after `upd` ends. The bench keeps a behavioural model that counts the cycles since launch. It samples at every falling clock edge and compares each output with the value the model expects for that cycle count. Writes and trigger edges that arrive during a transfer are applied to the model with the same one-cycle timing, so their effect shows up only in the frames that follow.

// File: rtl/chain_shifter_pkg.sv
package chain_shifter_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_SHIFT = 2'd1,
    CS_GAP   = 2'd2,
    CS_UPD   = 2'd3
  } cs_state_t;
endpackage

// File: rtl/chain_shifter_trig.sv
module chain_shifter_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/chain_shifter_lane.sv
module chain_shifter_lane #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  parameter int LEN_W  = 7,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              en,
  input  logic [LEN_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  output logic              sdo
);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] wsel;
  logic [BIT_W-1:0]  bsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Bit k is taken from word k/WORD_W, most significant bit first.
  always_comb begin
    wsel = ADDR_W'(idx >> BIT_W);
    bsel = BIT_W'(idx);
    sdo  = en && (idx < len) && mem[wsel][TOP_BIT - bsel];
  end
endmodule

// File: rtl/chain_shifter.sv
module chain_shifter
  import chain_shifter_pkg::*;
#(
  parameter int NUM_LANES = 5,
  parameter int WORD_W    = 16,
  parameter int WORDS     = 4,
  parameter int DIV_W     = 8,
  parameter int MIN_DIV   = 2,
  localparam int LANE_W   = $clog2(NUM_LANES),
  localparam int ADDR_W   = $clog2(WORDS),
  localparam int MAX_BITS = WORDS * WORD_W,
  localparam int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [LANE_W-1:0]          wr_lane,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [NUM_LANES*LEN_W-1:0] cfg_len,
  input  logic [DIV_W-1:0]           cfg_div,
  input  logic                       trig_in,
  output logic                       sclk,
  output logic [NUM_LANES-1:0]       sdo,
  output logic                       upd,
  output logic                       busy,
  output logic                       done,
  output logic                       overrun
);
  cs_state_t        st;
  logic [DIV_W-1:0] div_q, cnt, div_eff;
  logic [LEN_W-1:0] idx, tot, len_max;
  logic [LEN_W-1:0] len_q   [NUM_LANES];
  logic [LEN_W-1:0] len_clp [NUM_LANES];
  logic             sclk_q, trig_rise, wr_fire, phase_end;

  chain_shifter_trig u_trig (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise(trig_rise)
  );

  assign wr_ready  = (st == CS_IDLE);
  assign wr_fire   = wr_valid && wr_ready;
  assign busy      = (st != CS_IDLE);
  assign upd       = (st == CS_UPD);
  assign sclk      = sclk_q;
  assign phase_end = (cnt == div_q);
  assign div_eff   = (cfg_div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : cfg_div;

  always_comb begin
    len_max = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      len_clp[i] = (cfg_len[i*LEN_W +: LEN_W] > LEN_W'(MAX_BITS))
                   ? LEN_W'(MAX_BITS) : cfg_len[i*LEN_W +: LEN_W];
      if (len_clp[i] > len_max) len_max = len_clp[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CS_IDLE;
      div_q   <= DIV_W'(MIN_DIV);
      cnt     <= '0;
      idx     <= '0;
      tot     <= '0;
      sclk_q  <= 1'b0;
      done    <= 1'b0;
      overrun <= 1'b0;
      for (int i = 0; i < NUM_LANES; i++) len_q[i] <= '0;
    end else begin
      done <= 1'b0;
      if (trig_rise && st != CS_IDLE) overrun <= 1'b1;
      case (st)
        CS_IDLE: if (trig_rise) begin
          overrun <= 1'b0;
          div_q   <= div_eff;
          tot     <= len_max;
          for (int i = 0; i < NUM_LANES; i++) len_q[i] <= len_clp[i];
          cnt     <= '0;
          idx     <= '0;
          sclk_q  <= 1'b0;
          st      <= (len_max == '0) ? CS_GAP : CS_SHIFT;
        end
        CS_SHIFT: if (phase_end) begin
          cnt <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (idx == tot - LEN_W'(1)) st <= CS_GAP;
            else idx <= idx + LEN_W'(1);
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
        CS_GAP: if (phase_end) begin
          cnt <= '0;
          st  <= CS_UPD;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
        CS_UPD: if (phase_end) begin
          cnt  <= '0;
          st   <= CS_IDLE;
          done <= 1'b1;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    chain_shifter_lane #(.WORD_W(WORD_W), .WORDS(WORDS), .LEN_W(LEN_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .we(wr_fire && (wr_lane == LANE_W'(g))),
      .waddr(wr_addr), .wdata(wr_data),
      .en(st == CS_SHIFT), .idx(idx), .len(len_q[g]),
      .sdo(sdo[g])
    );
  end

  p_upd_no_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> !sclk);
  p_gap_before_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd) |-> (!$past(sclk) && $past(sdo) == '0));
  p_done_after_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(upd) && !upd && !busy));
  p_data_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_SHIFT && $past(st == CS_SHIFT) && !$fell(sclk)) |-> $stable(sdo));
  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy));
  p_ready_vs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> !wr_ready);
endmodule

// File: tb/test_chain_shifter.sv
module test_chain_shifter;
  localparam int L = 5;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [2:0]    wr_lane = '0;
  logic [1:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [L*LW-1:0] cfg_len = '0;
  logic [7:0]    cfg_div = '0;
  logic          trig_in = 1'b0;
  logic          sclk, upd, busy, done, overrun;
  logic [L-1:0]  sdo;

  int checks = 0, errors = 0, cyc = 0;

  chain_shifter i_chain_shifter (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_lane(wr_lane), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_div(cfg_div), .trig_in(trig_in),
    .sclk(sclk), .sdo(sdo), .upd(upd), .busy(busy), .done(done),
    .overrun(overrun)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  logic [15:0] mbuf [L][4];
  int  mlen [L];
  int  mP, mN, mt;
  bit  mbusy, mdone, movr, th1, th2, th3;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < L; l++) for (int w = 0; w < 4; w++) mbuf[l][w] = '0;
      mbusy = 0; mdone = 0; movr = 0; mt = 0; th1 = 0; th2 = 0; th3 = 0;
    end else begin
      bit rise, pre;
      rise = th2 && !th3;
      th3 = th2; th2 = th1; th1 = trig_in;
      pre = mbusy;
      mdone = 0;
      if (!pre && wr_valid && int'(wr_lane) < L) mbuf[wr_lane][wr_addr] = wr_data;
      if (pre) begin
        mt++;
        if (mt == 2*mN*mP + 2*mP) begin mbusy = 0; mdone = 1; end
      end
      if (rise) begin
        if (pre) movr = 1;
        else begin
          mP = ((int'(cfg_div) < 2) ? 2 : int'(cfg_div)) + 1;
          mN = 0;
          for (int l = 0; l < L; l++) begin
            mlen[l] = int'(cfg_len[l*LW +: LW]);
            if (mlen[l] > 64) mlen[l] = 64;
            if (mlen[l] > mN) mN = mlen[l];
          end
          mt = 0; mbusy = 1; movr = 0;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int esclk, eupd, k, T;
      esclk = 0; eupd = 0; k = 0; T = 2*mN*mP;
      if (mbusy && mt < T) begin
        k = mt / (2*mP);
        esclk = ((mt % (2*mP)) >= mP) ? 1 : 0;
      end
      if (mbusy && mt >= T + mP) eupd = 1;
      chk("R3 R8 busy", int'(busy), int'(mbusy));
      chk("R2 wr_ready", int'(wr_ready), int'(!mbusy));
      chk("R4 R10 sclk", int'(sclk), esclk);
      chk((mN == 0) ? "R11 upd" : "R7 upd", int'(upd), eupd);
      chk("R8 done", int'(done), int'(mdone));
      chk("R9 overrun", int'(overrun), int'(movr));
      for (int l = 0; l < L; l++) begin
        int eb;
        eb = 0;
        if (mbusy && mt < T && k < mlen[l]) eb = int'(mbuf[l][k/16][15-(k%16)]);
        if (mbusy && mt < T && k >= mlen[l]) chk("R6 sdo quiet", int'(sdo[l]), 0);
        else chk("R5 R2 sdo bit", int'(sdo[l]), eb);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000) begin
      errors++;
      $display("FAIL R8 watchdog: actual busy %0d expected 0", busy);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int lane, int addr, logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_lane = 3'(lane); wr_addr = 2'(addr); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse(int n);
    @(negedge clk);
    trig_in = 1'b1;
    repeat (n) @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (mbusy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [L*LW-1:0] lens(int a, int b, int c, int d, int e);
    return {7'(e), 7'(d), 7'(c), 7'(b), 7'(a)};
  endfunction

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 sdo", int'(sdo), 0);
    chk("R1 upd", int'(upd), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int l = 0; l < L; l++)
      for (int w = 0; w < 4; w++)
        wr(l, w, 16'hA5C3 ^ 16'(l * 16'h1357) ^ 16'(w * 16'h0F1E));

    // Transfer 1: mixed lengths, one above range (R6), divider clamped (R4)
    cfg_len = lens(16, 40, 64, 70, 0);
    cfg_div = 8'd0;
    pulse(2);
    repeat (30) @(negedge clk);
    wr(0, 0, 16'hFFFF);                // R2: rejected while busy
    cfg_len = lens(8, 8, 8, 8, 8);     // R10: no effect on running frame
    cfg_div = 8'd7;
    pulse(1);                          // R9: ignored, sets overrun
    wait_idle();

    // Transfer 2: held trigger launches once (R3); overrun cleared (R9)
    cfg_len = lens(3, 17, 33, 1, 64);
    cfg_div = 8'd4;
    pulse(60);
    wait_idle();
    wr(6, 1, 16'h1234);                // R2: out-of-range lane ignored
    wr(1, 1, 16'h8001);

    // Transfer 3: R11, all lengths zero
    cfg_len = lens(0, 0, 0, 0, 0);
    pulse(1);
    wait_idle();

    // Transfer 4: R5 R10 with new divider
    cfg_len = lens(32, 32, 5, 16, 48);
    cfg_div = 8'd3;
    pulse(1);
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule